// File: doc/BRIEF.md
# SDRAM Initialization Command Sequencer

This block issues the command sequence that brings an SDRAM out of power-up into a usable state. Software sets a one-shot request bit. Once no memory access is running, the sequencer closes every open row with a precharge-all command. It then issues three auto-refresh commands and finally a mode-register-set command. Every command goes to all SDRAM spaces at once. The request bit clears itself when the sequence ends, and a done flag rises.

The block also keeps three programmable timing fields: row cycle, precharge and activate-to-column delay. Each holds its cycle count minus one. The sequencer uses the precharge field to space precharge-all from the first refresh. It uses the row-cycle field to space each refresh from the command after it. The activate-to-column field is only held and shown for neighbouring access logic. The power-on settling wait, data transfers and the mode word itself are handled elsewhere. In every cycle without a command, the pins carry NOP.

Top module: `sdinit_sequencer`

## Requirements
- R1: After reset the pins carry NOP with A10 low, busy, done and pending are low, and the timing fields read row cycle 6, precharge 1, activate-to-column 1.
- R2: A one-cycle pulse on init_req sets init_pending at the next edge. If access_busy is low, precharge-all appears on the pins one cycle after pending rises.
- R3: While access_busy is high, an idle sequencer issues no command and stays not busy. It starts in the cycle after access_busy is sampled low with a request pending.
- R4: The first command is precharge-all, encoded as cs_n=0, ras_n=0, cas_n=1, we_n=0 with A10=1.
- R5: Exactly three auto-refresh commands follow, encoded as cs_n=0, ras_n=0, cas_n=0, we_n=1 with A10=0. The first one comes precharge+1 cycles after precharge-all.
- R6: Consecutive refreshes are row-cycle+1 cycles apart. Mode-register-set (all four strobes low, A10 low) comes row-cycle+1 cycles after the third refresh.
- R7: Every cycle without one of those commands carries NOP: cs_n=0, ras_n=1, cas_n=1, we_n=1, A10=0.
- R8: In the cycle after mode-register-set, busy falls, done rises and pending clears. Done falls again when the next sequence begins.
- R9: A timing write (tim_wr) updates all three fields when the sequencer is idle and is ignored while it is busy.
- R10: Busy is high from the precharge-all cycle through the mode-register-set cycle, and pending stays high throughout.
- R11: A request that arrives while a sequence is running does not start a second sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | Pulse that requests initialization |
| access_busy | input | 1 | High while a memory access is in progress |
| tim_wr | input | 1 | Write strobe for the three timing fields |
| tim_trc | input | TW | New row-cycle count minus one |
| tim_trp | input | TW | New precharge count minus one |
| tim_trcd | input | TW | New activate-to-column count minus one |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_a10 | output | 1 | Address bit 10, high to select all banks |
| init_pending | output | 1 | Request bit, cleared when the sequence ends |
| init_busy | output | 1 | Sequence in progress |
| init_done | output | 1 | Last sequence has completed |
| cur_trc | output | TW | Held row-cycle field |
| cur_trp | output | TW | Held precharge field |
| cur_trcd | output | TW | Held activate-to-column field |

## Verification
A corrupted gap counter or refresh tally appears on the command pins in the same run. A command then lands one or more cycles early or late, or the refresh count differs from three. The per-cycle comparison catches this in the cycle it happens. A bad state or flag register shows up within one cycle of the mode-register-set as a wrong busy or done value, or as a second sequence. Field values of zero and fifteen, together with a held-off start, exercise the counter boundaries and the start gating.

// File: rtl/sdinit_pkg.sv
`timescale 1ns/1ps
package sdinit_pkg;

  typedef enum logic [1:0] {
    CMD_NOP     = 2'd0,
    CMD_PREALL  = 2'd1,
    CMD_REFRESH = 2'd2,
    CMD_MODESET = 2'd3
  } sd_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_GAP_PRE = 2'd1,
    ST_GAP_REF = 2'd2,
    ST_FINISH  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic a10;
  } sd_pins_t;

  localparam sd_pins_t PINS_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};

  function automatic sd_pins_t encode_cmd(sd_cmd_e c);
    sd_pins_t p;
    p = PINS_NOP;
    case (c)
      CMD_PREALL:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
      CMD_REFRESH: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};
      CMD_MODESET: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0, a10: 1'b0};
      default:     p = PINS_NOP;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sdinit_timing_regs.sv
`timescale 1ns/1ps
module sdinit_timing_regs #(
  parameter int TW       = 4,
  parameter int DEF_TRC  = 6,
  parameter int DEF_TRP  = 1,
  parameter int DEF_TRCD = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          lock,
  input  logic [TW-1:0] in_trc,
  input  logic [TW-1:0] in_trp,
  input  logic [TW-1:0] in_trcd,
  output logic [TW-1:0] out_trc,
  output logic [TW-1:0] out_trp,
  output logic [TW-1:0] out_trcd
);

  localparam int NFIELD = 3;

  logic [TW-1:0] new_val [NFIELD];
  logic [TW-1:0] held    [NFIELD];
  logic          accept;

  assign accept     = wr_en && !lock;
  assign new_val[0] = in_trc;
  assign new_val[1] = in_trp;
  assign new_val[2] = in_trcd;

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    localparam int RESET_VAL = (g == 0) ? DEF_TRC : ((g == 1) ? DEF_TRP : DEF_TRCD);
    always_ff @(posedge clk) begin
      if (rst) begin
        held[g] <= TW'(RESET_VAL);
      end else if (accept) begin
        held[g] <= new_val[g];
      end
    end
  end

  assign out_trc  = held[0];
  assign out_trp  = held[1];
  assign out_trcd = held[2];

endmodule

// File: rtl/sdinit_gap_counter.sv
`timescale 1ns/1ps
module sdinit_gap_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         is_zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign is_zero = (cnt == '0);

endmodule

// File: rtl/sdinit_seq_fsm.sv
`timescale 1ns/1ps
module sdinit_seq_fsm
  import sdinit_pkg::*;
#(
  parameter int TW        = 4,
  parameter int REF_COUNT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_req,
  input  logic          access_busy,
  input  logic [TW-1:0] trc,
  input  logic [TW-1:0] trp,
  input  logic          gap_zero,
  output logic          gap_load,
  output logic [TW-1:0] gap_val,
  output sd_cmd_e       next_cmd,
  output logic          busy,
  output logic          done,
  output logic          pending
);

  localparam int RC_W = $clog2(REF_COUNT + 1);

  seq_state_e      st, st_n;
  logic [RC_W-1:0] refs, refs_n;
  logic            start;

  assign start = (st == ST_IDLE) && pending && !access_busy;

  always_comb begin
    st_n     = st;
    refs_n   = refs;
    next_cmd = CMD_NOP;
    gap_load = 1'b0;
    gap_val  = '0;
    case (st)
      ST_IDLE: begin
        if (start) begin
          next_cmd = CMD_PREALL;
          gap_load = 1'b1;
          gap_val  = trp;
          refs_n   = '0;
          st_n     = ST_GAP_PRE;
        end
      end
      ST_GAP_PRE: begin
        if (gap_zero) begin
          next_cmd = CMD_REFRESH;
          gap_load = 1'b1;
          gap_val  = trc;
          refs_n   = RC_W'(1);
          st_n     = ST_GAP_REF;
        end
      end
      ST_GAP_REF: begin
        if (gap_zero) begin
          if (refs == RC_W'(REF_COUNT)) begin
            next_cmd = CMD_MODESET;
            st_n     = ST_FINISH;
          end else begin
            next_cmd = CMD_REFRESH;
            gap_load = 1'b1;
            gap_val  = trc;
            refs_n   = refs + 1'b1;
          end
        end
      end
      ST_FINISH: begin
        st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      refs    <= '0;
      done    <= 1'b0;
      pending <= 1'b0;
    end else begin
      st   <= st_n;
      refs <= refs_n;
      if (start) begin
        done <= 1'b0;
      end else if (st == ST_FINISH) begin
        done <= 1'b1;
      end
      if (init_req) begin
        pending <= 1'b1;
      end else if (st == ST_FINISH) begin
        pending <= 1'b0;
      end
    end
  end

  assign busy = (st != ST_IDLE);

endmodule

// File: rtl/sdinit_pin_drv.sv
`timescale 1ns/1ps
module sdinit_pin_drv
  import sdinit_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  sd_cmd_e next_cmd,
  output logic    cs_n,
  output logic    ras_n,
  output logic    cas_n,
  output logic    we_n,
  output logic    a10
);

  sd_pins_t pins_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q <= PINS_NOP;
    end else begin
      pins_q <= encode_cmd(next_cmd);
    end
  end

  assign cs_n  = pins_q.cs_n;
  assign ras_n = pins_q.ras_n;
  assign cas_n = pins_q.cas_n;
  assign we_n  = pins_q.we_n;
  assign a10   = pins_q.a10;

endmodule

// File: rtl/sdinit_sequencer.sv
`timescale 1ns/1ps
module sdinit_sequencer
  import sdinit_pkg::*;
#(
  parameter int TW        = 4,
  parameter int REF_COUNT = 3,
  parameter int DEF_TRC   = 6,
  parameter int DEF_TRP   = 1,
  parameter int DEF_TRCD  = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_req,
  input  logic          access_busy,
  input  logic          tim_wr,
  input  logic [TW-1:0] tim_trc,
  input  logic [TW-1:0] tim_trp,
  input  logic [TW-1:0] tim_trcd,
  output logic          sd_cs_n,
  output logic          sd_ras_n,
  output logic          sd_cas_n,
  output logic          sd_we_n,
  output logic          sd_a10,
  output logic          init_pending,
  output logic          init_busy,
  output logic          init_done,
  output logic [TW-1:0] cur_trc,
  output logic [TW-1:0] cur_trp,
  output logic [TW-1:0] cur_trcd
);

  logic          gap_zero;
  logic          gap_load;
  logic [TW-1:0] gap_val;
  sd_cmd_e       next_cmd;

  sdinit_timing_regs #(
    .TW(TW), .DEF_TRC(DEF_TRC), .DEF_TRP(DEF_TRP), .DEF_TRCD(DEF_TRCD)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(tim_wr), .lock(init_busy),
    .in_trc(tim_trc), .in_trp(tim_trp), .in_trcd(tim_trcd),
    .out_trc(cur_trc), .out_trp(cur_trp), .out_trcd(cur_trcd)
  );

  sdinit_gap_counter #(.W(TW)) u_gap (
    .clk(clk), .rst(rst), .load(gap_load), .load_val(gap_val), .is_zero(gap_zero)
  );

  sdinit_seq_fsm #(.TW(TW), .REF_COUNT(REF_COUNT)) u_fsm (
    .clk(clk), .rst(rst), .init_req(init_req), .access_busy(access_busy),
    .trc(cur_trc), .trp(cur_trp), .gap_zero(gap_zero),
    .gap_load(gap_load), .gap_val(gap_val), .next_cmd(next_cmd),
    .busy(init_busy), .done(init_done), .pending(init_pending)
  );

  sdinit_pin_drv u_pins (
    .clk(clk), .rst(rst), .next_cmd(next_cmd),
    .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n), .a10(sd_a10)
  );

endmodule

// File: rtl/sdinit_chk.sv
`timescale 1ns/1ps
module sdinit_chk #(
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          access_busy,
  input logic          sd_ras_n,
  input logic          sd_cas_n,
  input logic          sd_we_n,
  input logic          sd_a10,
  input logic          init_pending,
  input logic          init_busy,
  input logic          init_done,
  input logic [TW-1:0] cur_trc,
  input logic [TW-1:0] cur_trp,
  input logic [TW-1:0] cur_trcd
);

  // R4
  first_is_preall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(init_busy) |-> (!sd_ras_n && sd_cas_n && !sd_we_n && sd_a10));

  // R3
  held_off_no_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (access_busy && !init_busy) |=> (sd_ras_n && sd_cas_n && sd_we_n && !init_busy));

  // R7
  idle_nop_chk: assert property (@(posedge clk) disable iff (rst)
    (!init_busy && !$past(init_busy)) |-> (sd_ras_n && sd_cas_n && sd_we_n && !sd_a10));

  // R8
  done_on_finish_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(init_busy) |-> init_done);

  // R9
  fields_locked_chk: assert property (@(posedge clk) disable iff (rst)
    init_busy |=> ($stable(cur_trc) && $stable(cur_trp) && $stable(cur_trcd)));

  // R10
  pending_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    init_busy |-> init_pending);

endmodule

bind sdinit_sequencer sdinit_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst(rst), .access_busy(access_busy),
  .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_a10(sd_a10),
  .init_pending(init_pending), .init_busy(init_busy), .init_done(init_done),
  .cur_trc(cur_trc), .cur_trp(cur_trp), .cur_trcd(cur_trcd)
);

// File: tb/tb_sdinit_sequencer.sv
`timescale 1ns/1ps
module tb_sdinit_sequencer;
  localparam int TW = 4;
  localparam int C_NOP = 0, C_PRE = 1, C_REF = 2, C_MRS = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, init_req = 1'b0, access_busy = 1'b0, tim_wr = 1'b0;
  logic [TW-1:0] tim_trc = '0, tim_trp = '0, tim_trcd = '0;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10;
  logic init_pending, init_busy, init_done;
  logic [TW-1:0] cur_trc, cur_trp, cur_trcd;

  sdinit_sequencer dut (.*);

  int checks = 0, fails = 0, cyc = 0;
  bit timed_out = 0;
  string phase = "R1";

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic int pins_of(int c);
    case (c)
      C_PRE:   return 5'b00101;
      C_REF:   return 5'b00010;
      C_MRS:   return 5'b00000;
      default: return 5'b01110;
    endcase
  endfunction

  // behavioural reference model
  int m_trc, m_trp, m_trcd, m_cmd, run_trc, run_trp;
  bit m_busy, m_done, m_pend, o_busy, o_pend;
  int o_trc, o_trp;
  int q[$];

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_trc = 6; m_trp = 1; m_trcd = 1; m_cmd = C_NOP;
      m_busy = 0; m_done = 0; m_pend = 0; q.delete();
    end else begin
      o_busy = m_busy; o_pend = m_pend; o_trc = m_trc; o_trp = m_trp;
      m_cmd = C_NOP;
      if (q.size() > 0) begin
        m_cmd = q.pop_front();
      end else if (o_busy) begin
        m_busy = 0; m_done = 1; m_pend = 0;
      end else if (o_pend && !access_busy) begin
        run_trc = o_trc; run_trp = o_trp;
        q.push_back(C_PRE);
        for (int i = 0; i < o_trp; i++) q.push_back(C_NOP);
        for (int r = 0; r < 3; r++) begin
          q.push_back(C_REF);
          for (int i = 0; i < o_trc; i++) q.push_back(C_NOP);
        end
        q.push_back(C_MRS);
        m_cmd = q.pop_front();
        m_busy = 1; m_done = 0;
      end
      if (init_req) m_pend = 1;
      if (tim_wr && !o_busy) begin
        m_trc = tim_trc; m_trp = tim_trp; m_trcd = tim_trcd;
      end
    end
  end

  // per-cycle comparison and command-spacing monitor
  int last_t = 0, last_c = C_NOP, ref_cnt = 0, runs = 0;
  always @(negedge clk) begin
    if (!rst) begin
      int p;
      p = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10};
      chk((m_cmd == C_NOP) ? "R7 pins" : {phase, " pins"}, p, pins_of(m_cmd));
      chk("R8 R10 flags", {init_busy, init_done, init_pending}, {m_busy, m_done, m_pend});
      chk("R9 fields", {cur_trc, cur_trp, cur_trcd}, {m_trc[TW-1:0], m_trp[TW-1:0], m_trcd[TW-1:0]});
      if (p == 5'b00101) begin
        last_t = cyc; last_c = C_PRE; ref_cnt = 0; runs++;
      end else if (p == 5'b00010) begin
        if (last_c == C_PRE) chk("R5 precharge gap", cyc - last_t, run_trp + 1);
        else chk("R6 refresh gap", cyc - last_t, run_trc + 1);
        last_t = cyc; last_c = C_REF; ref_cnt++;
      end else if (p == 5'b00000) begin
        chk("R6 modeset gap", cyc - last_t, run_trc + 1);
        chk("R5 refresh count", ref_cnt, 3);
        last_t = cyc; last_c = C_MRS;
      end
    end
  end

  task automatic pulse_req();
    @(negedge clk) init_req = 1'b1;
    @(negedge clk) init_req = 1'b0;
  endtask

  task automatic set_timing(int trc, int trp, int trcd);
    @(negedge clk);
    tim_wr = 1'b1; tim_trc = TW'(trc); tim_trp = TW'(trp); tim_trcd = TW'(trcd);
    @(negedge clk) tim_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!m_busy && !m_pend) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pins", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10}, 5'b01110);
    chk("R1 flags", {init_busy, init_done, init_pending}, 0);
    chk("R1 fields", {cur_trc, cur_trp, cur_trcd}, 12'h611);

    // R2: default timing run
    phase = "R2";
    @(negedge clk) init_req = 1'b1;
    @(negedge clk) init_req = 1'b0;
    chk("R2 pending", init_pending, 1);
    @(negedge clk);
    chk("R4 first cmd", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10}, 5'b00101);
    wait_idle();
    chk("R8 done", init_done, 1);

    // zero gaps, back-to-back commands
    phase = "R5";
    set_timing(0, 0, 2);
    chk("R9 idle write", {cur_trc, cur_trp, cur_trcd}, 12'h002);
    pulse_req();
    wait_idle();

    // widest gaps; write and request while busy (R9, R11)
    phase = "R6";
    set_timing(15, 3, 5);
    pulse_req();
    repeat (6) @(negedge clk);
    chk("R10 busy mid-run", init_busy, 1);
    set_timing(2, 2, 2);
    chk("R9 locked write", {cur_trc, cur_trp, cur_trcd}, 12'hF35);
    pulse_req();
    wait_idle();
    repeat (20) @(negedge clk);
    chk("R11 single run", runs, 3);

    // start held off by a running access
    phase = "R3";
    @(negedge clk) access_busy = 1'b1;
    pulse_req();
    repeat (10) @(negedge clk);
    chk("R3 held off", {init_busy, init_pending}, 2'b01);
    @(negedge clk) access_busy = 1'b0;
    @(negedge clk);
    chk("R3 start", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10}, 5'b00101);
    chk("R8 done cleared", init_done, 0);
    wait_idle();
    chk("R11 run total", runs, 4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    timed_out = 1;
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule